// File: doc/BRIEF.md
# Associative Region Access Counter Cache

The block watches a stream of memory transaction addresses and keeps a small, fully associative set of tag/counter pairs, one per recently referenced address region. Each address is reduced to a region number by dropping its low `REGION_SHIFT` bits. The region number is matched against every entry at once. A match bumps that entry's count. A miss claims a free entry. When no entry is free, the block tries to fold two neighbouring entries into one entry covering twice the span. If no such pair exists, it pushes the least recently touched entry out as a record.

Records leave through a write port addressed by a ring-buffer write pointer. Software drains the ring and reports its progress by writing a read pointer. If a record must leave while the ring is full, the block holds the record and raises an interrupt. It also stops accepting transactions until software frees a slot.

Top module: `region_access_cache`

## Requirements
- R1: The region number is `txn_addr_i >> REGION_SHIFT`. An entry of size level L covers the 2^L regions starting at its tag, and its tag is a multiple of 2^L. A transaction whose region lies inside a valid entry increments that entry's count and produces no record.
- R2: A miss while some entry is free writes the lowest-index free entry with tag = region, size level 0 and count 1, and produces no record.
- R3: On a miss with all entries valid, the block looks for a pair of entries (i, j) with i < j, taking the first in ascending order of i and then j. The pair must meet all of the following: equal size level L below the largest level; equal `tag >> (L+1)`; and a count sum that fits in `CNT_W` bits. If such a pair exists, entry i becomes tag with bit L cleared, level L+1 and the summed count. Entry j takes the new region at level 0 with count 1. No record is produced.
- R4: If no pair qualifies, the entry touched least recently is flushed as a record {tag, size level, count}, and its slot takes the new region at level 0 with count 1. A hit or a fill touches an entry; the surviving entry of a merge is not touched.
- R5: A hit on an entry whose count equals 2^CNT_W-1 produces a record carrying that maximum count. The entry keeps its tag and level, and its count restarts at 1.
- R6: A record is presented with `ring_we_o` high for one cycle, starting in the cycle after the accepting clock edge. `ring_slot_o` is the low `RING_AW` bits of the write pointer, and `wr_ptr_o` (`RING_AW+1` bits, wrapping) advances by one at the same edge. Records appear in the order they were produced.
- R7: The ring is full when `wr_ptr_o - rd_ptr` (modulo 2^(RING_AW+1)) equals 2^RING_AW. If a record is due while the ring is full, it is held, and `irq_o` goes high while `txn_ready_o` goes low, both from the next cycle. At the first edge that sees free space, the held record is written and `irq_o` returns low.
- R8: After reset, no entry is valid, both pointers are 0, `ring_we_o` and `irq_o` are low, and `txn_ready_o` is high.
- R9: While `txn_ready_o` is low, `txn_valid_i` is ignored and no entry changes.
- R10: A read-pointer write through `rd_ptr_we_i`/`rd_ptr_i` takes effect at that clock edge. The fullness seen at that same edge still uses the old read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| txn_valid_i | input | 1 | A transaction address is present |
| txn_addr_i | input | ADDR_W | Physical address of the transaction |
| txn_ready_o | output | 1 | Transaction accepted at this edge when high |
| rd_ptr_we_i | input | 1 | Software read-pointer write strobe |
| rd_ptr_i | input | RING_AW+1 | New ring read pointer |
| ring_we_o | output | 1 | Record write to the ring this cycle |
| ring_slot_o | output | RING_AW | Ring slot of the record |
| rec_tag_o | output | ADDR_W-REGION_SHIFT | Record base region number |
| rec_size_o | output | LVL_W | Record size level (log2 of regions covered) |
| rec_count_o | output | CNT_W | Record access count |
| wr_ptr_o | output | RING_AW+1 | Ring write pointer |
| irq_o | output | 1 | Ring overflow interrupt |

## Verification
Each record is due in the cycle after the edge that accepted its transaction, and a held record is due one edge after the edge at which the read-pointer write makes room. The interrupt and the ready drop are due in the cycle after the edge that found the ring full. The bench runs a behavioural model: per-slot timestamps for recency, plain loops for matching and pair search, and integer pointers. The model is stepped at each rising edge with the same inputs the design sees. The outputs of both are compared at the falling edge, so every expected value is taken in the exact cycle the requirement places it. The bench uses small entry, counter and ring sizes so that merges, saturation, eviction and ring overflow all occur within a few dozen transactions.

// File: rtl/rac_pkg.sv
package rac_pkg;
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_HIT,
    ACT_ALLOC,
    ACT_MERGE,
    ACT_EVICT
  } rac_act_e;
endpackage

// File: rtl/rac_match.sv
module rac_match #(
  parameter int N     = 16,
  parameter int TAG_W = 20,
  parameter int LVL_W = 2,
  parameter int IW    = 4
) (
  input  logic [N-1:0]     vld_i,
  input  logic [TAG_W-1:0] tag_i [N],
  input  logic [LVL_W-1:0] lvl_i [N],
  input  logic [TAG_W-1:0] region_i,
  output logic [N-1:0]     hit_vec_o,
  output logic             hit_o,
  output logic [IW-1:0]    hit_idx_o,
  output logic             free_o,
  output logic [IW-1:0]    free_idx_o
);
  for (genvar e = 0; e < N; e++) begin : g_cmp
    assign hit_vec_o[e] = vld_i[e] && (((region_i ^ tag_i[e]) >> lvl_i[e]) == '0);
  end

  assign hit_o  = |hit_vec_o;
  assign free_o = ~&vld_i;

  always_comb begin
    hit_idx_o  = '0;
    free_idx_o = '0;
    for (int e = N - 1; e >= 0; e--) begin
      if (hit_vec_o[e]) hit_idx_o = IW'(e);
      if (!vld_i[e]) free_idx_o = IW'(e);
    end
  end
endmodule

// File: rtl/rac_merge_pick.sv
module rac_merge_pick #(
  parameter int N     = 16,
  parameter int TAG_W = 20,
  parameter int LVL_W = 2,
  parameter int CNT_W = 24,
  parameter int IW    = 4
) (
  input  logic [N-1:0]     vld_i,
  input  logic [TAG_W-1:0] tag_i [N],
  input  logic [LVL_W-1:0] lvl_i [N],
  input  logic [CNT_W-1:0] cnt_i [N],
  output logic             found_o,
  output logic [IW-1:0]    a_idx_o,
  output logic [IW-1:0]    b_idx_o
);
  localparam logic [LVL_W-1:0] LVL_TOP = {LVL_W{1'b1}};

  logic [CNT_W:0] sum;

  // first qualifying pair in (i, j) order
  always_comb begin
    found_o = 1'b0;
    a_idx_o = '0;
    b_idx_o = '0;
    sum     = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        sum = {1'b0, cnt_i[i]} + {1'b0, cnt_i[j]};
        if (!found_o && vld_i[i] && vld_i[j] &&
            lvl_i[i] == lvl_i[j] && lvl_i[i] != LVL_TOP &&
            (tag_i[i] >> (int'(lvl_i[i]) + 1)) == (tag_i[j] >> (int'(lvl_i[j]) + 1)) &&
            !sum[CNT_W]) begin
          found_o = 1'b1;
          a_idx_o = IW'(i);
          b_idx_o = IW'(j);
        end
      end
    end
  end
endmodule

// File: rtl/rac_lru.sv
module rac_lru #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          touch_i,
  input  logic [IW-1:0] touch_idx_i,
  output logic [IW-1:0] victim_o
);
  localparam logic [IW-1:0] AGE_OLD = IW'(N - 1);

  logic [IW-1:0] age_q [N];
  logic [N-1:0]  oldest;

  for (genvar e = 0; e < N; e++) begin : g_old
    assign oldest[e] = (age_q[e] == AGE_OLD);
  end

  always_comb begin
    victim_o = '0;
    for (int e = 0; e < N; e++) if (oldest[e]) victim_o = IW'(e);
  end

  // ages stay a permutation of 0..N-1; 0 is most recent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < N; e++) age_q[e] <= IW'(e);
    end else if (touch_i) begin
      for (int e = 0; e < N; e++) begin
        if (IW'(e) == touch_idx_i) age_q[e] <= '0;
        else if (age_q[e] < age_q[touch_idx_i]) age_q[e] <= age_q[e] + 1'b1;
      end
    end
  end

  // R4
  one_oldest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(oldest) == 1);
endmodule

// File: rtl/rac_ring.sv
module rac_ring #(
  parameter int RING_AW = 6,
  parameter int TAG_W   = 20,
  parameter int LVL_W   = 2,
  parameter int CNT_W   = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [TAG_W-1:0]   tag_i,
  input  logic [LVL_W-1:0]   lvl_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               rd_we_i,
  input  logic [RING_AW:0]   rd_ptr_i,
  output logic               ready_o,
  output logic               we_o,
  output logic [RING_AW-1:0] slot_o,
  output logic [TAG_W-1:0]   tag_o,
  output logic [LVL_W-1:0]   lvl_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [RING_AW:0]   wr_ptr_o,
  output logic               irq_o
);
  localparam logic [RING_AW:0] DEPTH = (RING_AW + 1)'(1 << RING_AW);

  logic [RING_AW:0]   wr_q, rd_q;
  logic               pend_q, irq_q, we_q;
  logic [RING_AW-1:0] slot_q;
  logic [TAG_W-1:0]   tag_q;
  logic [LVL_W-1:0]   lvl_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               full;

  assign full = (wr_q - rd_q) == DEPTH;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
      we_q   <= 1'b0;
      slot_q <= '0;
      tag_q  <= '0;
      lvl_q  <= '0;
      cnt_q  <= '0;
    end else begin
      we_q <= 1'b0;
      if (rd_we_i) rd_q <= rd_ptr_i;
      if (pend_q) begin
        if (!full) begin
          we_q   <= 1'b1;
          slot_q <= wr_q[RING_AW-1:0];
          wr_q   <= wr_q + 1'b1;
          pend_q <= 1'b0;
          irq_q  <= 1'b0;
        end
      end else if (req_i) begin
        tag_q <= tag_i;
        lvl_q <= lvl_i;
        cnt_q <= cnt_i;
        if (!full) begin
          we_q   <= 1'b1;
          slot_q <= wr_q[RING_AW-1:0];
          wr_q   <= wr_q + 1'b1;
        end else begin
          pend_q <= 1'b1;
          irq_q  <= 1'b1;
        end
      end
    end
  end

  assign ready_o  = !pend_q;
  assign we_o     = we_q;
  assign slot_o   = slot_q;
  assign tag_o    = tag_q;
  assign lvl_o    = lvl_q;
  assign cnt_o    = cnt_q;
  assign wr_ptr_o = wr_q;
  assign irq_o    = irq_q;

  // R6
  wr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> wr_q == $past(wr_q) + 1'b1);
  // R7
  occ_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_q - rd_q) <= DEPTH);
  // R7
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && full && !pend_q) |=> (pend_q && irq_q && !we_q));
endmodule

// File: rtl/region_access_cache.sv
module region_access_cache
  import rac_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int REGION_SHIFT = 12,
  parameter int NUM_ENT      = 16,
  parameter int CNT_W        = 24,
  parameter int LVL_W        = 2,
  parameter int RING_AW      = 6,
  localparam int TAG_W       = ADDR_W - REGION_SHIFT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               txn_valid_i,
  input  logic [ADDR_W-1:0]  txn_addr_i,
  output logic               txn_ready_o,
  input  logic               rd_ptr_we_i,
  input  logic [RING_AW:0]   rd_ptr_i,
  output logic               ring_we_o,
  output logic [RING_AW-1:0] ring_slot_o,
  output logic [TAG_W-1:0]   rec_tag_o,
  output logic [LVL_W-1:0]   rec_size_o,
  output logic [CNT_W-1:0]   rec_count_o,
  output logic [RING_AW:0]   wr_ptr_o,
  output logic               irq_o
);
  localparam int IW = $clog2(NUM_ENT);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NUM_ENT-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [NUM_ENT];
  logic [LVL_W-1:0]   lvl_q [NUM_ENT];
  logic [CNT_W-1:0]   cnt_q [NUM_ENT];

  logic [TAG_W-1:0]   region;
  logic               accept;
  logic [NUM_ENT-1:0] hit_vec;
  logic               hit, free, mrg_found;
  logic [IW-1:0]      hit_idx, free_idx, mrg_a, mrg_b, victim;
  rac_act_e           act;
  logic [IW-1:0]      touch_idx;
  logic               flush_req;
  logic [TAG_W-1:0]   fl_tag;
  logic [LVL_W-1:0]   fl_lvl;
  logic [CNT_W-1:0]   fl_cnt;

  assign region = txn_addr_i[ADDR_W-1:REGION_SHIFT];
  assign accept = txn_valid_i && txn_ready_o;

  rac_match #(.N(NUM_ENT), .TAG_W(TAG_W), .LVL_W(LVL_W), .IW(IW)) i_match (
    .vld_i     (vld_q),
    .tag_i     (tag_q),
    .lvl_i     (lvl_q),
    .region_i  (region),
    .hit_vec_o (hit_vec),
    .hit_o     (hit),
    .hit_idx_o (hit_idx),
    .free_o    (free),
    .free_idx_o(free_idx)
  );

  rac_merge_pick #(.N(NUM_ENT), .TAG_W(TAG_W), .LVL_W(LVL_W), .CNT_W(CNT_W), .IW(IW)) i_merge (
    .vld_i  (vld_q),
    .tag_i  (tag_q),
    .lvl_i  (lvl_q),
    .cnt_i  (cnt_q),
    .found_o(mrg_found),
    .a_idx_o(mrg_a),
    .b_idx_o(mrg_b)
  );

  rac_lru #(.N(NUM_ENT), .IW(IW)) i_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .touch_i    (accept),
    .touch_idx_i(touch_idx),
    .victim_o   (victim)
  );

  always_comb begin
    act = ACT_NONE;
    if (accept) begin
      if (hit)            act = ACT_HIT;
      else if (free)      act = ACT_ALLOC;
      else if (mrg_found) act = ACT_MERGE;
      else                act = ACT_EVICT;
    end
    unique case (act)
      ACT_HIT:   touch_idx = hit_idx;
      ACT_ALLOC: touch_idx = free_idx;
      ACT_MERGE: touch_idx = mrg_b;
      default:   touch_idx = victim;
    endcase
    flush_req = (act == ACT_HIT && cnt_q[hit_idx] == CNT_MAX) || act == ACT_EVICT;
    if (act == ACT_HIT) begin
      fl_tag = tag_q[hit_idx];
      fl_lvl = lvl_q[hit_idx];
      fl_cnt = CNT_MAX;
    end else begin
      fl_tag = tag_q[victim];
      fl_lvl = lvl_q[victim];
      fl_cnt = cnt_q[victim];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int e = 0; e < NUM_ENT; e++) begin
        tag_q[e] <= '0;
        lvl_q[e] <= '0;
        cnt_q[e] <= '0;
      end
    end else begin
      unique case (act)
        ACT_HIT: begin
          if (cnt_q[hit_idx] == CNT_MAX) cnt_q[hit_idx] <= CNT_W'(1);
          else cnt_q[hit_idx] <= cnt_q[hit_idx] + 1'b1;
        end
        ACT_ALLOC: begin
          vld_q[free_idx] <= 1'b1;
          tag_q[free_idx] <= region;
          lvl_q[free_idx] <= '0;
          cnt_q[free_idx] <= CNT_W'(1);
        end
        ACT_MERGE: begin
          tag_q[mrg_a] <= tag_q[mrg_a] & ~(TAG_W'(1) << lvl_q[mrg_a]);
          lvl_q[mrg_a] <= lvl_q[mrg_a] + LVL_W'(1);
          cnt_q[mrg_a] <= cnt_q[mrg_a] + cnt_q[mrg_b];
          tag_q[mrg_b] <= region;
          lvl_q[mrg_b] <= '0;
          cnt_q[mrg_b] <= CNT_W'(1);
        end
        ACT_EVICT: begin
          tag_q[victim] <= region;
          lvl_q[victim] <= '0;
          cnt_q[victim] <= CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

  rac_ring #(.RING_AW(RING_AW), .TAG_W(TAG_W), .LVL_W(LVL_W), .CNT_W(CNT_W)) i_ring (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (flush_req),
    .tag_i   (fl_tag),
    .lvl_i   (fl_lvl),
    .cnt_i   (fl_cnt),
    .rd_we_i (rd_ptr_we_i),
    .rd_ptr_i(rd_ptr_i),
    .ready_o (txn_ready_o),
    .we_o    (ring_we_o),
    .slot_o  (ring_slot_o),
    .tag_o   (rec_tag_o),
    .lvl_o   (rec_size_o),
    .cnt_o   (rec_count_o),
    .wr_ptr_o(wr_ptr_o),
    .irq_o   (irq_o)
  );

  // R1
  single_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  // R9
  stall_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txn_ready_o |=> $stable(vld_q));

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent_chk
    // R5
    cnt_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_q[e] |-> cnt_q[e] != '0);
    // R1
    tag_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_q[e] |-> ((tag_q[e] >> lvl_q[e]) << lvl_q[e]) == tag_q[e]);
  end
endmodule

// File: tb/test_region_access_cache.sv
`timescale 1ns/1ps
module test_region_access_cache;
  localparam int AW = 16, SH = 4, NE = 4, CW = 4, LW = 2, RAW = 2;
  localparam int TW = AW - SH;
  localparam int MAXC = (1 << CW) - 1;
  localparam int MAXL = (1 << LW) - 1;
  localparam int DEP = 1 << RAW;
  localparam int PMOD = 2 * DEP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txn_valid = 1'b0;
  logic [AW-1:0] txn_addr = '0;
  logic rd_we = 1'b0;
  logic [RAW:0] rd_ptr = '0;
  logic txn_ready, ring_we, irq;
  logic [RAW-1:0] ring_slot;
  logic [TW-1:0] rec_tag;
  logic [LW-1:0] rec_size;
  logic [CW-1:0] rec_count;
  logic [RAW:0] wr_ptr;

  always #2.5 clk = ~clk;

  region_access_cache #(.ADDR_W(AW), .REGION_SHIFT(SH), .NUM_ENT(NE), .CNT_W(CW),
                        .LVL_W(LW), .RING_AW(RAW)) i_region_access_cache (
    .clk_i(clk), .rst_ni(rst_n), .txn_valid_i(txn_valid), .txn_addr_i(txn_addr),
    .txn_ready_o(txn_ready), .rd_ptr_we_i(rd_we), .rd_ptr_i(rd_ptr),
    .ring_we_o(ring_we), .ring_slot_o(ring_slot), .rec_tag_o(rec_tag),
    .rec_size_o(rec_size), .rec_count_o(rec_count), .wr_ptr_o(wr_ptr), .irq_o(irq)
  );

  int compared = 0, mismatched = 0, cycles = 0;
  string cur_req = "R8";

  // reference model
  bit m_vld[NE];
  int m_tag[NE], m_lvl[NE], m_cnt[NE], m_stamp[NE];
  int now_t, m_wr, m_rd;
  bit m_pend, m_irq, e_we;
  int e_slot, e_tag, e_lvl, e_cnt;

  task automatic model_reset();
    for (int e = 0; e < NE; e++) begin
      m_vld[e] = 0; m_tag[e] = 0; m_lvl[e] = 0; m_cnt[e] = 0; m_stamp[e] = 0;
    end
    now_t = 0; m_wr = 0; m_rd = 0; m_pend = 0; m_irq = 0; e_we = 0;
    e_slot = 0; e_tag = 0; e_lvl = 0; e_cnt = 0;
  endtask

  task automatic model_step();
    int region, h, f, a, b, v, ft, flv, fc;
    bit fl, full;
    fl = 0; ft = 0; flv = 0; fc = 0;
    if (txn_valid && !m_pend) begin
      region = int'(txn_addr) >> SH;
      h = -1; f = -1; a = -1; b = -1;
      for (int e = 0; e < NE; e++)
        if (m_vld[e] && ((region ^ m_tag[e]) >> m_lvl[e]) == 0) h = e;
      for (int e = NE - 1; e >= 0; e--) if (!m_vld[e]) f = e;
      now_t++;
      if (h >= 0) begin
        if (m_cnt[h] == MAXC) begin
          fl = 1; ft = m_tag[h]; flv = m_lvl[h]; fc = MAXC; m_cnt[h] = 1;
        end else m_cnt[h]++;
        m_stamp[h] = now_t;
      end else if (f >= 0) begin
        m_vld[f] = 1; m_tag[f] = region; m_lvl[f] = 0; m_cnt[f] = 1; m_stamp[f] = now_t;
      end else begin
        for (int i = 0; i < NE; i++)
          for (int j = i + 1; j < NE; j++)
            if (a < 0 && m_lvl[i] == m_lvl[j] && m_lvl[i] < MAXL &&
                (m_tag[i] >> (m_lvl[i] + 1)) == (m_tag[j] >> (m_lvl[i] + 1)) &&
                m_cnt[i] + m_cnt[j] <= MAXC) begin
              a = i; b = j;
            end
        if (a >= 0) begin
          m_tag[a] = m_tag[a] & ~(1 << m_lvl[a]);
          m_lvl[a]++;
          m_cnt[a] = m_cnt[a] + m_cnt[b];
          m_tag[b] = region; m_lvl[b] = 0; m_cnt[b] = 1; m_stamp[b] = now_t;
        end else begin
          v = 0;
          for (int e = 1; e < NE; e++) if (m_stamp[e] < m_stamp[v]) v = e;
          fl = 1; ft = m_tag[v]; flv = m_lvl[v]; fc = m_cnt[v];
          m_tag[v] = region; m_lvl[v] = 0; m_cnt[v] = 1; m_stamp[v] = now_t;
        end
      end
    end
    full = (((m_wr - m_rd) % PMOD + PMOD) % PMOD) == DEP;
    e_we = 0;
    if (m_pend) begin
      if (!full) begin
        e_we = 1; e_slot = m_wr % DEP; m_wr = (m_wr + 1) % PMOD; m_pend = 0; m_irq = 0;
      end
    end else if (fl) begin
      e_tag = ft; e_lvl = flv; e_cnt = fc;
      if (!full) begin
        e_we = 1; e_slot = m_wr % DEP; m_wr = (m_wr + 1) % PMOD;
      end else begin
        m_pend = 1; m_irq = 1;
      end
    end
    if (rd_we) m_rd = int'(rd_ptr);
  endtask

  initial model_reset();
  always @(posedge clk) if (!rst_n) model_reset(); else model_step();

  task automatic chk(bit ok, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk(txn_ready == !m_pend, "txn_ready_o", int'(txn_ready), int'(!m_pend));
    chk(irq == m_irq, "irq_o", int'(irq), int'(m_irq));
    chk(ring_we == e_we, "ring_we_o", int'(ring_we), int'(e_we));
    chk(int'(wr_ptr) == m_wr, "wr_ptr_o", int'(wr_ptr), m_wr);
    if (e_we) begin
      chk(int'(ring_slot) == e_slot, "ring_slot_o", int'(ring_slot), e_slot);
      chk(int'(rec_tag) == e_tag, "rec_tag_o", int'(rec_tag), e_tag);
      chk(int'(rec_size) == e_lvl, "rec_size_o", int'(rec_size), e_lvl);
      chk(int'(rec_count) == e_cnt, "rec_count_o", int'(rec_count), e_cnt);
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  task automatic step(bit v, int region, bit drain);
    @(negedge clk);
    txn_valid = v;
    txn_addr = AW'((region << SH) | $urandom_range(0, (1 << SH) - 1));
    rd_we = drain;
    rd_ptr = (RAW + 1)'(m_wr);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0);
  endtask

  initial begin
    // R8 reset state, compared each cycle
    cur_req = "R8";
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    // R1 hits on one region
    cur_req = "R1";
    for (int k = 0; k < 3; k++) step(1, 3, 0);
    // R2 fill free slots
    cur_req = "R2";
    step(1, 7, 0); step(1, 8, 0); step(1, 9, 0);
    // R3 buddies 8,9 fold; 20 takes freed slot
    cur_req = "R3";
    step(1, 20, 0);
    step(1, 9, 0);
    step(1, 8, 0);
    idle(2);
    // R4 no pair: least recent entry leaves as a record
    cur_req = "R4";
    step(1, 40, 0);
    idle(2);
    step(1, 64, 0);
    idle(2);
    // R5 saturate region 40
    cur_req = "R5";
    for (int k = 0; k < 17; k++) step(1, 40, 0);
    idle(2);
    // R10 drain
    cur_req = "R10";
    step(0, 0, 1);
    idle(2);
    // R3 pair whose sum would not fit is not folded
    cur_req = "R3";
    for (int k = 0; k < 9; k++) step(1, 100, 0);
    for (int k = 0; k < 9; k++) step(1, 101, 0);
    step(1, 130, 0); step(1, 170, 0);
    step(1, 210, 0);
    idle(2);
    step(0, 0, 1);
    // R6 record order and slots
    cur_req = "R6";
    for (int k = 0; k < 3; k++) step(1, 300 + 4 * k, 0);
    idle(2);
    // R7 overflow: no drain
    cur_req = "R7";
    for (int k = 0; k < 8; k++) step(1, 500 + 4 * k, 0);
    // R9 valid ignored while stalled
    cur_req = "R9";
    for (int k = 0; k < 5; k++) step(1, 700 + 4 * k, 0);
    cur_req = "R7";
    step(0, 0, 1);
    idle(3);
    cur_req = "R9";
    for (int k = 0; k < 4; k++) step(1, 900 + 4 * k, 0);
    step(0, 0, 1);
    idle(3);
    // mixed traffic
    cur_req = "R4";
    for (int k = 0; k < 3000; k++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 15), $urandom_range(0, 7) == 0);
    step(0, 0, 1);
    idle(4);
    finish_run();
  end
endmodule